// File: doc/BRIEF.md
# SPI Byte Master

This block is a single-byte SPI master that sits on a Wishbone slave port. Software writes a configuration word and then a byte to the data register. The block drives a chip-select line, generates SCK from a programmable divider, and shifts the byte out on SDO while it collects a byte from SDI. When the eighth bit has been exchanged, the received byte becomes readable and the interrupt line pulses for one clock.

The configuration word selects the divider, the bit order, the chip-select polarity, the clock mode and streaming. In streaming mode the chip select stays active between bytes, so a multi-byte frame can be built one byte at a time. While a byte is in flight the configuration is frozen. The only exception is clearing the enable bit, which aborts the byte at once.

Top module: `spi_byte_master`

## Requirements
- R1: Word offset 0x0 (byte address bits 3:2 = 0) holds the configuration: bits 7:0 divider, bit 8 LSB-first, bit 9 active-high chip select, bit 11 clock mode, bit 12 streaming, bit 13 enable, and bit 15 a read-only busy flag. Offset 0x4 is the data register. After reset both offsets read 0, SCK is low and the chip select is inactive.
- R2: A data write while enabled and idle starts a transfer of the written byte's bits 7:0. Busy reads 1 from that write until the transfer completes.
- R3: SCK toggles exactly 16 times, once every divider+1 clocks. The first toggle comes divider+1 clocks after the write is accepted, and completion comes divider+1 clocks after the last toggle.
- R4: In mode 0 (bit 11 = 0), SDO presents the first bit before the first SCK edge and changes only on falling edges. SDI is sampled on rising edges.
- R5: In mode 1 (bit 11 = 1), SDO changes on rising edges and SDI is sampled on falling edges. In both modes SCK rests low when no byte is in flight.
- R6: Bit 8 = 0 sends and receives the most significant bit first. Bit 8 = 1 sends and receives the least significant bit first.
- R7: With bit 9 = 0 the chip-select pin is active low (idles high). With bit 9 = 1 it is active high (idles low). The pin follows the bit from the clock edge that writes it.
- R8: With streaming off, the chip select is active from the accepting edge to the completion edge, and inactive from then on.
- R9: With streaming on, the chip select stays active after completion. It goes inactive one clock after a configuration write that clears bit 12.
- R10: At completion the received byte is readable at offset 0x4, and the interrupt output is high for exactly that one clock.
- R11: A data write while disabled or busy is ignored. No transfer starts and the byte in flight is unchanged.
- R12: A configuration write while busy is ignored if bit 13 is 1. If bit 13 is 0, it is stored and aborts the byte: busy clears, SCK returns low, the chip select goes inactive, no interrupt is raised and the read data is kept.
- R13: Each access gets a single-cycle acknowledge on the clock after it is presented. Offsets other than 0x0 and 0x4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle active |
| wb_stb_i | input | 1 | Strobe for this slave |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | ADDR_W | Byte address; bits 3:2 pick the register |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Access acknowledge |
| spi_sck_o | output | 1 | Serial clock |
| spi_sdo_o | output | 1 | Serial data out |
| spi_sdi_i | input | 1 | Serial data in |
| spi_cs_o | output | 1 | Chip select, polarity set by configuration |
| irq_o | output | 1 | One-cycle completion pulse |

## Verification
The bench aims at the edges of the SCK schedule: a divider of zero, the half period before the first toggle and the one after the last. A design that miscounted any of these would shift SCK or the interrupt by a cycle against the reference model. Both clock modes are run with both bit orders against a behavioural slave. An engine that sampled on the wrong edge or reversed the order would return a mangled byte in one direction or the other. The bench also checks that the streaming chip select is held and then released one clock late, that data and configuration writes made mid-byte are discarded, and that an abort leaves no interrupt and no stale busy flag. A design that let a mid-byte write through would corrupt the outgoing byte or change SCK timing under way.

// File: rtl/spi_byte_master.sv
`timescale 1ns/1ps
module spi_byte_master #(
  parameter int ADDR_W = 4,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [ADDR_W-1:0] wb_adr_i,
  input  logic [31:0]       wb_dat_i,
  output logic [31:0]       wb_dat_o,
  output logic              wb_ack_o,
  output logic              spi_sck_o,
  output logic              spi_sdo_o,
  input  logic              spi_sdi_i,
  output logic              spi_cs_o,
  output logic              irq_o
);
  localparam int NBITS     = 8;
  localparam int LAST_EDGE = 2 * NBITS;
  localparam int ECW       = $clog2(LAST_EDGE + 1);

  logic [DIV_W-1:0] cfg_div, hcnt;
  logic             cfg_lsb, cfg_inv, cfg_mode, cfg_stream, cfg_en;
  logic             busy, cs_active, sck_q, sdo_q, irq_q, ack_q;
  logic [ECW-1:0]   ecnt;
  logic [3:0]       nbit;
  logic [7:0]       tx_q, rx_sh, rx_q;
  logic [31:0]      dat_q;

  function automatic logic pick(input logic [7:0] d, input logic [2:0] i, input logic lsb);
    pick = lsb ? d[i] : d[3'd7 - i];
  endfunction

  logic [1:0] word;
  logic       acc, wr_cfg, wr_dat, start, abort_x, tick, finish, cfg_upd;
  logic [2:0] rxpos;

  assign word    = wb_adr_i[3:2];
  assign acc     = wb_cyc_i & wb_stb_i & ~ack_q;
  assign wr_cfg  = acc & wb_we_i & (word == 2'd0);
  assign wr_dat  = acc & wb_we_i & (word == 2'd1);
  assign start   = wr_dat & cfg_en & ~busy;
  assign abort_x = wr_cfg & busy & ~wb_dat_i[13];
  assign cfg_upd = wr_cfg & (~busy | ~wb_dat_i[13]);
  assign tick    = busy & (hcnt == '0);
  assign finish  = tick & (ecnt == ECW'(LAST_EDGE));
  assign rxpos   = cfg_lsb ? nbit[2:0] : 3'd7 - nbit[2:0];

  logic [31:0] rd_mux;
  always_comb begin
    case (word)
      2'd0:    rd_mux = {16'd0, busy, 1'b0, cfg_en, cfg_stream, cfg_mode, 1'b0,
                         cfg_inv, cfg_lsb, 8'(cfg_div)};
      2'd1:    rd_mux = {24'd0, rx_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cfg_div <= '0; cfg_lsb <= 1'b0; cfg_inv <= 1'b0; cfg_mode <= 1'b0;
      cfg_stream <= 1'b0; cfg_en <= 1'b0;
      busy <= 1'b0; cs_active <= 1'b0; sck_q <= 1'b0; sdo_q <= 1'b0;
      irq_q <= 1'b0; ack_q <= 1'b0; dat_q <= '0;
      hcnt <= '0; ecnt <= '0; nbit <= '0;
      tx_q <= '0; rx_sh <= '0; rx_q <= '0;
    end else begin
      ack_q <= acc;
      irq_q <= 1'b0;
      if (acc) dat_q <= wb_we_i ? 32'd0 : rd_mux;

      if (cfg_upd) begin
        cfg_div    <= wb_dat_i[DIV_W-1:0];
        cfg_lsb    <= wb_dat_i[8];
        cfg_inv    <= wb_dat_i[9];
        cfg_mode   <= wb_dat_i[11];
        cfg_stream <= wb_dat_i[12];
        cfg_en     <= wb_dat_i[13];
      end

      if (start) begin
        busy  <= 1'b1;
        hcnt  <= cfg_div;
        ecnt  <= '0;
        nbit  <= '0;
        tx_q  <= wb_dat_i[7:0];
        rx_sh <= '0;
        sdo_q <= pick(wb_dat_i[7:0], 3'd0, cfg_lsb);
      end else if (abort_x) begin
        busy  <= 1'b0;
        sck_q <= 1'b0;
      end else if (busy) begin
        if (!tick) begin
          hcnt <= hcnt - 1'b1;
        end else begin
          hcnt <= cfg_div;
          if (finish) begin
            busy  <= 1'b0;
            irq_q <= 1'b1;
            rx_q  <= rx_sh;
          end else begin
            ecnt  <= ecnt + 1'b1;
            sck_q <= ~sck_q;
            if (!sck_q) begin
              if (!cfg_mode) rx_sh[rxpos] <= spi_sdi_i;
              else           sdo_q <= pick(tx_q, nbit[2:0], cfg_lsb);
            end else begin
              nbit <= nbit + 1'b1;
              if (!cfg_mode) begin
                if (nbit != 4'd7) sdo_q <= pick(tx_q, nbit[2:0] + 3'd1, cfg_lsb);
              end else begin
                rx_sh[rxpos] <= spi_sdi_i;
              end
            end
          end
        end
      end

      if (start)                        cs_active <= 1'b1;
      else if (abort_x)                 cs_active <= 1'b0;
      else if (finish)                  cs_active <= cfg_stream;
      else if (!busy && !cfg_stream)    cs_active <= 1'b0;
    end
  end

  assign wb_dat_o  = dat_q;
  assign wb_ack_o  = ack_q;
  assign spi_sck_o = sck_q;
  assign spi_sdo_o = sdo_q;
  assign spi_cs_o  = cfg_inv ? cs_active : ~cs_active;
  assign irq_o     = irq_q;

  AST_ACK_PULSE:    assert property (@(posedge clk_i) disable iff (rst_i) ack_q |=> !ack_q); // R13
  AST_IRQ_PULSE:    assert property (@(posedge clk_i) disable iff (rst_i) irq_q |=> !irq_q); // R10
  AST_IRQ_AT_END:   assert property (@(posedge clk_i) disable iff (rst_i) irq_q |-> (!busy && $past(busy))); // R10
  AST_SCK_REST_LOW: assert property (@(posedge clk_i) disable iff (rst_i) !busy |-> !sck_q); // R5
  AST_CS_HELD:      assert property (@(posedge clk_i) disable iff (rst_i) busy |-> cs_active); // R8
  AST_SDO_HOLD_M0:  assert property (@(posedge clk_i) disable iff (rst_i)
                      (busy && !cfg_mode && $rose(sck_q)) |-> $stable(sdo_q)); // R4
  AST_SDO_HOLD_M1:  assert property (@(posedge clk_i) disable iff (rst_i)
                      (busy && cfg_mode && $fell(sck_q)) |-> $stable(sdo_q)); // R5
  AST_CFG_FROZEN:   assert property (@(posedge clk_i) disable iff (rst_i)
                      (busy && $past(busy)) |-> ($stable(cfg_div) && $stable(cfg_mode) && $stable(cfg_lsb))); // R12
endmodule

// File: tb/test_spi_byte_master.sv
`timescale 1ns/1ps
module test_spi_byte_master;
  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic cyc = 0, stb = 0, we = 0, sdi = 0;
  logic [3:0] adr = 0;
  logic [31:0] dati = 0;
  logic [31:0] dato;
  logic ack, sck, sdo, cs, irq;

  spi_byte_master i_spi_byte_master (
    .clk_i(clk), .rst_i(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(dati), .wb_dat_o(dato), .wb_ack_o(ack),
    .spi_sck_o(sck), .spi_sdo_o(sdo), .spi_sdi_i(sdi), .spi_cs_o(cs), .irq_o(irq));

  int errors = 0, checks = 0, ncyc = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit pickb(input bit [7:0] d, input int i, input bit lsb);
    return lsb ? d[i] : d[7-i];
  endfunction

  // reference model
  bit busy_e, sck_e, cs_e, irq_e, ack_e;
  int cnt, hp;
  bit [7:0] m_div;
  bit m_lsb, m_inv, m_mode, m_stream, m_en;

  always @(posedge clk) begin
    ncyc++;
    if (rst) begin
      busy_e = 0; sck_e = 0; cs_e = 0; irq_e = 0; ack_e = 0; cnt = 0; hp = 1;
      m_div = 0; m_lsb = 0; m_inv = 0; m_mode = 0; m_stream = 0; m_en = 0;
    end else begin
      bit a, ob, os, oen, ab, st;
      bit [7:0] odiv;
      a = cyc && stb && !ack_e;
      ob = busy_e; os = m_stream; oen = m_en; odiv = m_div;
      irq_e = 0; st = 0;
      ab = a && we && adr[3:2] == 0 && ob && !dati[13];
      if (ab) begin
        busy_e = 0; sck_e = 0; cs_e = 0;
      end else if (ob) begin
        cnt++;
        if (cnt % hp == 0) begin
          if (cnt / hp <= 16) sck_e = !sck_e;
          else begin busy_e = 0; irq_e = 1; cs_e = os; end
        end
      end
      if (a && we && adr[3:2] == 0 && (!ob || !dati[13])) begin
        m_div = dati[7:0]; m_lsb = dati[8]; m_inv = dati[9];
        m_mode = dati[11]; m_stream = dati[12]; m_en = dati[13];
      end
      if (a && we && adr[3:2] == 1 && oen && !ob) begin
        st = 1; busy_e = 1; cnt = 0; cs_e = 1; hp = odiv + 1;
      end
      if (!ob && !os && !st) cs_e = 0;
      ack_e = a;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(sck == sck_e, "R3", "sck", sck, sck_e);
      chk(cs == (m_inv ? cs_e : !cs_e), "R8", "cs pin", cs, m_inv ? cs_e : !cs_e);
      chk(irq == irq_e, "R10", "irq", irq, irq_e);
      chk(ack == ack_e, "R13", "ack", ack, ack_e);
    end
  end

  // behavioural slave
  bit [7:0] sbyte, srx;
  int sj, rc;
  bit psck = 0;
  always @(negedge clk) begin
    if (sck != psck) begin
      if (sck) begin
        if (!m_mode) begin if (rc < 8) srx[m_lsb ? rc : 7-rc] = sdo; rc++; end
        else if (sj < 8) sdi = pickb(sbyte, sj, m_lsb);
      end else begin
        if (!m_mode) begin sj++; if (sj < 8) sdi = pickb(sbyte, sj, m_lsb); end
        else begin if (rc < 8) srx[m_lsb ? rc : 7-rc] = sdo; rc++; sj++; end
      end
      psck = sck;
    end
  end

  task automatic prep_slave(input bit [7:0] b);
    sbyte = b; sj = 0; rc = 0; srx = 0; sdi = pickb(b, 0, m_lsb);
  endtask

  task automatic wb_write(input bit [3:0] a, input bit [31:0] d);
    @(negedge clk); cyc = 1; stb = 1; we = 1; adr = a; dati = d;
    @(negedge clk); cyc = 0; stb = 0; we = 0;
  endtask

  task automatic wb_read(input bit [3:0] a, output bit [31:0] d);
    @(negedge clk); cyc = 1; stb = 1; we = 0; adr = a;
    @(negedge clk); d = dato; cyc = 0; stb = 0;
  endtask

  task automatic wait_idle();
    while (busy_e) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_xfer(input bit [7:0] tx, input bit [7:0] sb, input string req);
    bit [31:0] v;
    prep_slave(sb);
    wb_write(4'h4, {24'd0, tx});
    wait_idle();
    chk(srx == tx, req, "byte seen by slave", srx, tx);
    wb_read(4'h4, v);
    chk(v == {24'd0, sb}, "R10", "received byte", v, sb);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) if (ncyc > 60000) begin
    errors++; checks++;
    $display("FAIL R2 watchdog: actual=%0d expected<60000 cycles", ncyc);
    summary();
  end

  initial begin
    bit [31:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(sck == 0, "R1", "reset sck", sck, 0);
    chk(cs == 1, "R1", "reset cs pin", cs, 1);
    chk(irq == 0, "R1", "reset irq", irq, 0);
    wb_read(4'h0, v); chk(v == 0, "R1", "reset cfg", v, 0);
    wb_read(4'h4, v); chk(v == 0, "R1", "reset data", v, 0);

    // mode 0, MSB first
    wb_write(4'h0, 32'h2001);
    run_xfer(8'hA5, 8'h3C, "R4");

    // busy flag
    wb_write(4'h0, 32'h2003);
    prep_slave(8'h00);
    wb_write(4'h4, 32'h0F);
    wb_read(4'h0, v); chk(v == 32'hA003, "R2", "cfg with busy", v, 32'hA003);
    wait_idle();
    wb_read(4'h0, v); chk(v == 32'h2003, "R2", "cfg after done", v, 32'h2003);

    // LSB first, divider 0
    wb_write(4'h0, 32'h2100);
    run_xfer(8'h1E, 8'hB2, "R6");

    // mode 1
    wb_write(4'h0, 32'h2802);
    run_xfer(8'h96, 8'h4D, "R5");
    wb_write(4'h0, 32'h2900);
    run_xfer(8'h0F, 8'hE1, "R6");

    // inverted chip select
    wb_write(4'h0, 32'h2200);
    chk(cs == 0, "R7", "inverted idle cs", cs, 0);
    prep_slave(8'hCC);
    wb_write(4'h4, 32'h33);
    chk(cs == 1, "R7", "inverted active cs", cs, 1);
    wait_idle();
    chk(srx == 8'h33, "R7", "byte with inverted cs", srx, 8'h33);

    // streaming
    wb_write(4'h0, 32'h3000);
    run_xfer(8'h5A, 8'h11, "R9");
    chk(cs == 0, "R9", "cs held after byte", cs, 0);
    run_xfer(8'hC3, 8'h22, "R9");
    wb_write(4'h0, 32'h2000);
    chk(cs == 0, "R9", "cs one cycle after clear", cs, 0);
    @(negedge clk);
    chk(cs == 1, "R9", "cs released", cs, 1);

    // disabled write ignored
    wb_write(4'h0, 32'h0000);
    wb_write(4'h4, 32'hFF);
    repeat (20) @(negedge clk);
    wb_read(4'h0, v); chk(v == 0, "R11", "no busy when disabled", v, 0);
    wb_read(4'h4, v); chk(v == 32'h22, "R11", "data kept when disabled", v, 32'h22);

    // writes while busy
    wb_write(4'h0, 32'h2002);
    prep_slave(8'h55);
    wb_write(4'h4, 32'h81);
    wb_write(4'h4, 32'h7E);
    wb_write(4'h0, 32'h2803);
    wait_idle();
    chk(srx == 8'h81, "R11", "byte in flight kept", srx, 8'h81);
    wb_read(4'h0, v); chk(v == 32'h2002, "R12", "cfg frozen", v, 32'h2002);
    wb_read(4'h4, v); chk(v == 32'h55, "R10", "rx after busy writes", v, 32'h55);

    // abort
    wb_write(4'h0, 32'h2003);
    prep_slave(8'hF0);
    wb_write(4'h4, 32'h99);
    repeat (10) @(negedge clk);
    wb_write(4'h0, 32'h0003);
    chk(sck == 0, "R12", "sck after abort", sck, 0);
    chk(cs == 1, "R12", "cs after abort", cs, 1);
    wb_read(4'h0, v); chk(v == 32'h0003, "R12", "cfg after abort", v, 32'h0003);
    wb_read(4'h4, v); chk(v == 32'h55, "R12", "rx kept after abort", v, 32'h55);
    repeat (40) @(negedge clk);

    wb_read(4'h8, v); chk(v == 0, "R13", "unused offset", v, 0);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule